// File: doc/BRIEF.md
# Dual-Width ROM Read Port

This block is a synthesizable read-only memory with a read interface that behaves like a static parallel ROM. Two active-low strobes control the data bus. A chip-select strobe `ce_n` chooses standby or active operation. An output strobe `oe_n` gates the data onto the bus. A width-select input picks one of two organisations:

- **Word mode:** 16-bit words, one per address.
- **Byte mode:** 8-bit bytes. The most significant data pin stops being an output and becomes the lowest byte-address bit.

The data bus is modelled as a pad interface for the chip's pad ring, which combines the three parts into the real bidirectional pins:

- `dq_o` carries the output value.
- `dq_oe` is a per-bit output enable.
- `dq15_i` carries the value on the top pin when that pin is used as an input.

The part's access times are modelled in clock cycles. Data appears `ACC_LAT` rising edges after the access changes, and `OE_LAT` rising edges after the output strobe falls. Any change removes data from the bus at once. An identification input stands for a detector of an over-voltage on an address line. While it is high, the block returns a fixed manufacturer code or device code, chosen by `addr[0]`.

The contents come from a parameterised generator. Word `i` holds `(i * 0x9E37 + SEED) mod 2^16`. `DEPTH` words are stored, and the address selects one modulo `DEPTH`. The port is a plain asynchronous-style control interface, so it has no flow control. Outputs simply follow the strobes and the latency counters.

Top module: `dual_width_rom`

## Requirements
- R1: While `rst_n` is low, and after reset until an access has settled, `dq_oe` is all zero.
- R2: In word mode (`word_mode`=1, `hv_id`=0), a settled access with `ce_n`=0 and `oe_n`=0 drives all 16 bits. `dq_o` equals word `addr mod DEPTH`, and word `i` holds `(i*0x9E37 + SEED) mod 2^16`.
- R3: In byte mode (`word_mode`=0), `dq15_i`=0 places bits 7:0 of the addressed word on `dq_o[7:0]`, and `dq15_i`=1 places bits 15:8 there.
- R4: In byte mode, `dq_oe` is 0x00FF. Bits 14:8 are high-impedance, and bit 15 is never driven because it serves as an address input.
- R5: With `ce_n`=1, `dq_oe` is zero in the same cycle, whatever `oe_n` does.
- R6: With `oe_n`=1, `dq_oe` is zero in the same cycle.
- R7: A change of `addr`, `word_mode`, `hv_id` or (in byte mode) `dq15_i` clears `dq_oe` at once. After `ce_n` falls or the access changes, the output stays undriven for `ACC_LAT`-1 rising edges and is driven after the `ACC_LAT`-th.
- R8: After `oe_n` falls with the access settled, the output stays undriven for `OE_LAT`-1 rising edges and is driven after the `OE_LAT`-th.
- R9: With `hv_id`=1, `addr[0]`=0 returns the manufacturer code 0x20 and `addr[0]`=1 returns the device code 0xB1 on `dq_o[7:0]`. In word mode `dq_o[15:8]` reads 0x00.
- R10: In identification mode, address bits above bit 0 have no effect on the code returned. Users are expected to hold them low.
- R11: Addresses alias modulo `DEPTH`, so addresses that differ only above the index bits return the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that times the latency counters |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip select; high means standby |
| oe_n | input | 1 | Active-low output gate |
| word_mode | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| hv_id | input | 1 | Identification detect; returns fixed codes |
| addr | input | ADDR_W | Word address |
| dq15_i | input | 1 | Top pin as input: byte select in byte mode |
| dq_o | output | 16 | Data toward the pads |
| dq_oe | output | 16 | Per-bit pad output enable |

## Verification
Random accesses mix the two widths, both byte halves and occasional identification reads. Each access is checked once it has settled, so any mistake in the lane or byte selection shows up as a data or enable mismatch.

Directed cases cover the following:
- Reads one edge before and exactly at both latencies, which separates a correct access counter from one that is off by one.
- Standby and output disable with the other strobe held both ways.
- Identification reads with the upper address bits set, which show that only bit 0 picks the code.
- An address pair that differs only above the index bits, which exposes any failure to alias.

// File: rtl/rom_pkg.sv
package rom_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = WORD_W / 2;
  localparam logic [BYTE_W-1:0] MFR_CODE = 8'h20;
  localparam logic [BYTE_W-1:0] DEV_CODE = 8'hB1;
  localparam logic [31:0] GEN_MULT = 32'h0000_9E37;

  typedef enum logic [1:0] {
    RD_WORD    = 2'd0,
    RD_BYTE_LO = 2'd1,
    RD_BYTE_HI = 2'd2
  } rd_kind_e;

  // Content generator: word i = (i * GEN_MULT + seed) mod 2^WORD_W
  function automatic logic [WORD_W-1:0] init_word(input int unsigned idx,
                                                  input logic [WORD_W-1:0] seed);
    logic [31:0] p;
    p = idx * GEN_MULT + {16'h0000, seed};
    return p[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/rom_store.sv
module rom_store
  import rom_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter logic [WORD_W-1:0] SEED = 16'h5A3C,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    assign mem[i] = init_word(i, SEED);
  end

  assign word = mem[idx];
endmodule

// File: rtl/rom_settle.sv
// Counts rising edges since an event; done once LAT edges have passed.
module rom_settle #(
  parameter int LAT = 4,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,     // forces the count back to zero
  input  logic restart,  // counts this edge as the first one
  output logic done
);
  localparam logic [CW-1:0] MAX = CW'(LAT);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (hold)       cnt <= '0;
    else if (restart)    cnt <= CW'(1);
    else if (cnt != MAX) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == MAX);
endmodule

// File: rtl/rom_outsel.sv
module rom_outsel
  import rom_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  rd_kind_e          kind,
  input  logic              id_mode,
  input  logic              a0,
  output logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] mask
);
  logic [BYTE_W-1:0] lane;

  always_comb begin
    lane = (kind == RD_BYTE_HI) ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
    if (id_mode)
      data = {{BYTE_W{1'b0}}, (a0 ? DEV_CODE : MFR_CODE)};
    else if (kind == RD_WORD)
      data = word;
    else
      data = {{BYTE_W{1'b0}}, lane};
    mask = (kind == RD_WORD) ? '1 : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
  end
endmodule

// File: rtl/dual_width_rom.sv
module dual_width_rom
  import rom_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DEPTH = 256,
  parameter logic [WORD_W-1:0] SEED = 16'h5A3C,
  parameter int ACC_LAT = 4,
  parameter int OE_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              word_mode,
  input  logic              hv_id,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dq15_i,
  output logic [WORD_W-1:0] dq_o,
  output logic [WORD_W-1:0] dq_oe
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int KEY_W = ADDR_W + 3;

  logic              byte_bit;
  logic [KEY_W-1:0]  key, key_q;
  logic              key_chg;
  logic              acc_done, oe_done, ready;
  rd_kind_e          kind;
  logic [WORD_W-1:0] word, data, mask;

  // Everything that selects what the bus carries
  assign byte_bit = ~word_mode & dq15_i;
  assign key      = {addr, word_mode, byte_bit, hv_id};
  assign key_chg  = (key != key_q);

  always_ff @(posedge clk) begin
    if (!rst_n) key_q <= '0;
    else        key_q <= key;
  end

  always_comb begin
    if (word_mode)   kind = RD_WORD;
    else if (dq15_i) kind = RD_BYTE_HI;
    else             kind = RD_BYTE_LO;
  end

  rom_store #(.DEPTH(DEPTH), .SEED(SEED)) u_store (
    .idx  (addr[IDX_W-1:0]),
    .word (word)
  );

  rom_settle #(.LAT(ACC_LAT)) u_acc (
    .clk (clk), .rst_n (rst_n), .hold (ce_n), .restart (key_chg), .done (acc_done)
  );

  rom_settle #(.LAT(OE_LAT)) u_oe (
    .clk (clk), .rst_n (rst_n), .hold (oe_n), .restart (1'b0), .done (oe_done)
  );

  rom_outsel u_sel (
    .word (word), .kind (kind), .id_mode (hv_id), .a0 (addr[0]),
    .data (data), .mask (mask)
  );

  assign ready = acc_done & ~key_chg & oe_done & ~ce_n & ~oe_n & rst_n;
  assign dq_o  = data;
  assign dq_oe = ready ? mask : '0;
endmodule

// File: rtl/rom_port_checker.sv
module rom_port_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              word_mode,
  input logic              hv_id,
  input logic [ADDR_W-1:0] addr,
  input logic              dq15_i,
  input logic [15:0]       dq_o,
  input logic [15:0]       dq_oe
);
  a_r5_standby_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (dq_oe == 16'h0000));

  a_r6_oe_high_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (dq_oe == 16'h0000));

  a_r4_byte_upper_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |-> (dq_oe[15:8] == 8'h00));

  a_r7_addr_change_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != $past(addr)) |-> (dq_oe == 16'h0000));

  a_r8_oe_fall_blank: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(oe_n) && !oe_n) |-> (dq_oe == 16'h0000));

  a_r9_id_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_id && word_mode && dq_oe != 16'h0000) |-> (dq_o[15:8] == 8'h00));

  a_r2_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != 16'h0000 && $past(dq_oe) != 16'h0000 && $stable(addr) &&
     $stable(word_mode) && $stable(hv_id) && $stable(dq15_i)) |-> $stable(dq_o));
endmodule

bind dual_width_rom rom_port_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .oe_n (oe_n),
  .word_mode (word_mode), .hv_id (hv_id), .addr (addr), .dq15_i (dq15_i),
  .dq_o (dq_o), .dq_oe (dq_oe)
);

// File: tb/dual_width_rom_test.sv
`timescale 1ns/1ps
module dual_width_rom_test;
  localparam int ADDR_W = 20;
  localparam int DEPTH = 256;
  localparam logic [15:0] SEED = 16'h5A3C;
  localparam int ACC_LAT = 4;
  localparam int OE_LAT = 2;

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, word_mode, hv_id, dq15_i;
  logic [ADDR_W-1:0] addr;
  logic [15:0] dq_o, dq_oe;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dual_width_rom #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .SEED(SEED),
                   .ACC_LAT(ACC_LAT), .OE_LAT(OE_LAT)) uut (
    .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .oe_n (oe_n),
    .word_mode (word_mode), .hv_id (hv_id), .addr (addr), .dq15_i (dq15_i),
    .dq_o (dq_o), .dq_oe (dq_oe)
  );

  function automatic logic [15:0] content(input logic [ADDR_W-1:0] a);
    logic [31:0] p;
    p = (32'(a) % DEPTH) * 32'h9E37 + {16'h0, SEED};
    return p[15:0];
  endfunction

  function automatic logic [15:0] exp_oe(input logic wm);
    return wm ? 16'hFFFF : 16'h00FF;
  endfunction

  function automatic logic [15:0] exp_data(input logic [ADDR_W-1:0] a, input logic wm,
                                           input logic b, input logic hv);
    logic [15:0] w;
    if (hv) return {8'h00, (a[0] ? 8'hB1 : 8'h20)};
    w = content(a);
    if (wm) return w;
    return {8'h00, (b ? w[15:8] : w[7:0])};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_read(input string tag, input logic [ADDR_W-1:0] a, input logic wm,
                            input logic b, input logic hv);
    check({tag, " enable"}, dq_oe, exp_oe(wm));
    check({tag, " data"}, dq_o & dq_oe, exp_data(a, wm, b, hv) & exp_oe(wm));
  endtask

  task automatic set_access(input logic [ADDR_W-1:0] a, input logic wm,
                            input logic b, input logic hv);
    @(negedge clk);
    addr = a; word_mode = wm; dq15_i = b; hv_id = hv;
  endtask

  task automatic settle(input int edges);
    repeat (edges) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] ra;
    logic rw, rb, rh;
    void'($urandom(32'd1234));
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; word_mode = 1'b1; hv_id = 1'b0;
    dq15_i = 1'b0; addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", dq_oe, 16'h0000);
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    check("R1 in reset strobes low", dq_oe, 16'h0000);
    rst_n = 1'b1;
    #1 check("R1 after reset unsettled", dq_oe, 16'h0000);

    // R2 word read
    set_access(20'h00003, 1'b1, 1'b0, 1'b0);
    settle(ACC_LAT);
    check_read("R2 word read", 20'h00003, 1'b1, 1'b0, 1'b0);

    // R7 latency edges
    set_access(20'h00010, 1'b1, 1'b0, 1'b0);
    #1 check("R7 blank at change", dq_oe, 16'h0000);
    settle(ACC_LAT - 1);
    check("R7 one edge early", dq_oe, 16'h0000);
    settle(1);
    check_read("R7 at latency", 20'h00010, 1'b1, 1'b0, 1'b0);

    // R3 / R4 byte halves
    set_access(20'h00005, 1'b0, 1'b0, 1'b0);
    settle(ACC_LAT);
    check_read("R3 byte low", 20'h00005, 1'b0, 1'b0, 1'b0);
    set_access(20'h00005, 1'b0, 1'b1, 1'b0);
    settle(ACC_LAT);
    check_read("R3 byte high", 20'h00005, 1'b0, 1'b1, 1'b0);
    check("R4 upper lanes undriven", dq_oe & 16'hFF00, 16'h0000);

    // R11 aliasing
    set_access(20'h12305, 1'b1, 1'b0, 1'b0);
    settle(ACC_LAT);
    check("R11 alias data", dq_o, content(20'h00005));

    // R5 standby
    @(negedge clk); ce_n = 1'b1;
    #1 check("R5 standby oe low", dq_oe, 16'h0000);
    @(negedge clk); oe_n = 1'b1;
    #1 check("R5 standby oe high", dq_oe, 16'h0000);
    @(negedge clk); ce_n = 1'b0;
    settle(ACC_LAT + 1);
    check("R6 oe high", dq_oe, 16'h0000);

    // R8 output-gate latency
    @(negedge clk); oe_n = 1'b0;
    settle(OE_LAT - 1);
    check("R8 one edge early", dq_oe, 16'h0000);
    settle(1);
    check_read("R8 at latency", 20'h12305, 1'b1, 1'b0, 1'b0);
    @(negedge clk); oe_n = 1'b1;
    #1 check("R6 immediate disable", dq_oe, 16'h0000);
    @(negedge clk); oe_n = 1'b0;
    settle(OE_LAT);

    // R9 / R10 identification
    set_access(20'h00000, 1'b1, 1'b0, 1'b1);
    settle(ACC_LAT);
    check_read("R9 manufacturer code", 20'h00000, 1'b1, 1'b0, 1'b1);
    set_access(20'h00001, 1'b1, 1'b0, 1'b1);
    settle(ACC_LAT);
    check_read("R9 device code", 20'h00001, 1'b1, 1'b0, 1'b1);
    set_access(20'hABCD1, 1'b1, 1'b0, 1'b1);
    settle(ACC_LAT);
    check("R10 upper bits ignored", dq_o, 16'h00B1);
    set_access(20'h7F0E0, 1'b0, 1'b1, 1'b1);
    settle(ACC_LAT);
    check_read("R10 byte-mode id", 20'h7F0E0, 1'b0, 1'b1, 1'b1);

    // Random accesses
    for (int i = 0; i < 200; i++) begin
      ra = ADDR_W'($urandom);
      rw = 1'($urandom);
      rb = 1'($urandom);
      rh = ($urandom % 8) == 0;
      set_access(ra, rw, rb, rh);
      settle(ACC_LAT);
      check_read(rh ? "R9 random id" : (rw ? "R2 random word" : "R3 random byte"),
                 ra, rw, rb, rh);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule